// File: doc/BRIEF.md
# Sync-Aligned Serial Even-Parity Frame Checker

This block watches a serial bit stream and checks each frame for even parity. A frame is opened by a one-cycle sync strobe. After that the checker accepts exactly eight bits, one on each cycle where the bit-valid strobe is high. The first seven are data bits and the eighth is the parity bit. A running parity bit flips for every accepted one and holds for every accepted zero. When the eighth bit arrives, the block reports the result. An odd total number of ones means the frame failed even parity.

The result appears as two registered one-cycle pulses, frame-done and parity-error, in the cycle after the eighth bit is accepted. Once a frame has completed, the checker stays disarmed and ignores bits until the next sync. A sync at any point restarts the frame count and clears the parity. Generating the parity and passing the data bits on to a consumer are left to other blocks.

Top module: `even_parity_frame_chk`

## Requirements
- R1: After a synchronous reset (rst high at a clock edge), frame_done_o and parity_err_o are 0 and the checker is disarmed, so it accepts no bits until a sync.
- R2: A sync (sync_i high) restarts the frame from any state: the position returns to 0 and the running parity to 0, including in the middle of a frame.
- R3: A frame is DATA_BITS+1 accepted bits (default 7 data bits then 1 parity bit). frame_done_o pulses only after the final bit, never after an earlier one.
- R4: A bit is accepted only in a cycle with bit_valid_i high. Each accepted 1 toggles the running parity, each accepted 0 leaves it unchanged, and cycles with bit_valid_i low neither advance the frame nor change the parity.
- R5: With frame_done_o, parity_err_o is 1 when the frame's ones count is odd and 0 when it is even.
- R6: Bits offered before the first sync after reset are ignored and produce no pulse.
- R7: Bits offered after a frame completes and before the next sync are ignored and produce no pulse.
- R8: frame_done_o and parity_err_o are single-cycle pulses that start in the cycle after the final bit is accepted. parity_err_o is never high without frame_done_o.
- R9: When sync_i and bit_valid_i are high in the same cycle, the sync is taken and that bit is dropped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| sync_i | input | 1 | Frame-start strobe |
| bit_valid_i | input | 1 | Qualifies bit_i in this cycle |
| bit_i | input | 1 | Serial bit value |
| frame_done_o | output | 1 | One-cycle pulse after the final bit of a frame |
| parity_err_o | output | 1 | One-cycle pulse with frame_done_o when parity is odd |

## Verification
The bench targets a sync that lands in the middle of a frame. If the position or parity were not cleared, frame_done_o would fire early and the parity verdict would be inverted. It also drives a sync together with a valid 1 bit: a design that accepted that bit would complete one bit too soon with the wrong parity. Streams are sent before the first sync and after a completed frame, where a checker that stays armed would emit extra pulses. Idle gaps inside frames catch a design that counts cycles instead of valid bits.

// File: rtl/epc_pkg.sv
package epc_pkg;
  // Result of one checked frame, registered at the output stage.
  typedef struct packed {
    logic done;
    logic err;
  } epc_result_t;
endpackage

// File: rtl/epc_position.sv
module epc_position #(
  parameter int FRAME_LEN = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic sync_i,
  input  logic valid_i,
  output logic take_o,
  output logic last_o
);
  localparam int POS_W = (FRAME_LEN > 2) ? $clog2(FRAME_LEN) : 1;
  localparam logic [POS_W-1:0] LAST_POS = POS_W'(FRAME_LEN - 1);

  logic             armed_q;
  logic [POS_W-1:0] pos_q;

  assign take_o = armed_q & valid_i & ~sync_i;
  assign last_o = take_o & (pos_q == LAST_POS);

  always_ff @(posedge clk) begin
    if (rst) begin
      armed_q <= 1'b0;
      pos_q   <= '0;
    end else if (sync_i) begin
      armed_q <= 1'b1;
      pos_q   <= '0;
    end else if (take_o) begin
      if (pos_q == LAST_POS) begin
        armed_q <= 1'b0;
        pos_q   <= '0;
      end else begin
        pos_q <= pos_q + POS_W'(1);
      end
    end
  end

  // A sync always leaves the counter armed at position zero.
  assert_sync_restart_R2: assert property (@(posedge clk) disable iff (rst)
    sync_i |=> (armed_q && pos_q == '0));
  // After the final bit, nothing is accepted until a new sync.
  assert_disarm_after_frame_R7: assert property (@(posedge clk) disable iff (rst)
    (last_o && !sync_i) |=> !armed_q);
  // A sync together with a valid bit never consumes the bit.
  assert_sync_priority_R9: assert property (@(posedge clk) disable iff (rst)
    (sync_i && valid_i) |-> !take_o);
endmodule

// File: rtl/epc_parity.sv
module epc_parity (
  input  logic clk,
  input  logic rst,
  input  logic clear_i,
  input  logic take_i,
  input  logic bit_i,
  output logic odd_next_o
);
  logic par_q;

  assign odd_next_o = par_q ^ bit_i;

  always_ff @(posedge clk) begin
    if (rst || clear_i) par_q <= 1'b0;
    else if (take_i)    par_q <= par_q ^ bit_i;
  end

  assert_parity_cleared_R2: assert property (@(posedge clk) disable iff (rst)
    clear_i |=> !par_q);
  assert_parity_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (!clear_i && !take_i) |=> $stable(par_q));
  assert_parity_zero_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (!clear_i && take_i && !bit_i) |=> $stable(par_q));
endmodule

// File: rtl/epc_result.sv
module epc_result
  import epc_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic last_i,
  input  logic odd_i,
  output logic done_o,
  output logic err_o
);
  epc_result_t res_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      res_q <= '0;
    end else begin
      res_q.done <= last_i;
      res_q.err  <= last_i & odd_i;
    end
  end

  assign done_o = res_q.done;
  assign err_o  = res_q.err;

  assert_err_needs_done_R8: assert property (@(posedge clk) disable iff (rst)
    err_o |-> done_o);
  assert_done_single_R8: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);
endmodule

// File: rtl/even_parity_frame_chk.sv
module even_parity_frame_chk #(
  parameter int DATA_BITS = 7
) (
  input  logic clk,
  input  logic rst,
  input  logic sync_i,
  input  logic bit_valid_i,
  input  logic bit_i,
  output logic frame_done_o,
  output logic parity_err_o
);
  localparam int FRAME_LEN = DATA_BITS + 1;

  logic take;
  logic last;
  logic odd_next;

  epc_position #(.FRAME_LEN(FRAME_LEN)) u_pos (
    .clk     (clk),
    .rst     (rst),
    .sync_i  (sync_i),
    .valid_i (bit_valid_i),
    .take_o  (take),
    .last_o  (last)
  );

  epc_parity u_par (
    .clk        (clk),
    .rst        (rst),
    .clear_i    (sync_i),
    .take_i     (take),
    .bit_i      (bit_i),
    .odd_next_o (odd_next)
  );

  epc_result u_res (
    .clk    (clk),
    .rst    (rst),
    .last_i (last),
    .odd_i  (odd_next),
    .done_o (frame_done_o),
    .err_o  (parity_err_o)
  );

  // The done pulse follows a final-bit acceptance by exactly one cycle.
  assert_done_timing_R3: assert property (@(posedge clk) disable iff (rst)
    frame_done_o |-> $past(last));
  assert_done_follows_last_R8: assert property (@(posedge clk) disable iff (rst)
    last |=> frame_done_o);
endmodule

// File: tb/tb_even_parity_frame_chk.sv
module tb_even_parity_frame_chk;
  logic clk = 1'b0;
  logic rst, sync_i, bit_valid_i, bit_i;
  logic frame_done_o, parity_err_o;
  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  even_parity_frame_chk dut (
    .clk(clk), .rst(rst), .sync_i(sync_i), .bit_valid_i(bit_valid_i),
    .bit_i(bit_i), .frame_done_o(frame_done_o), .parity_err_o(parity_err_o)
  );

  // {gap_flag, frame bits}; bit 0 is sent first, bit 7 is the parity bit.
  localparam logic [8:0] VEC [8] = '{
    9'h000, 9'h1FF, 9'h001, 9'h180, 9'h055, 9'h157, 9'h0A3, 9'h17F
  };

  task automatic step(input logic s, input logic v, input logic b);
    @(negedge clk);
    sync_i = s; bit_valid_i = v; bit_i = b;
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input logic dn, input logic er,
                     input logic exp_dn, input logic exp_er);
    checks++;
    if (dn !== exp_dn || er !== exp_er) begin
      errors++;
      $display("FAIL %s done/err actual %b/%b expected %b/%b",
               req, dn, er, exp_dn, exp_er);
    end
  endtask

  task automatic idle_check(input string req);
    step(1'b0, 1'b0, 1'b0);
    chk(req, frame_done_o, parity_err_o, 1'b0, 1'b0);
  endtask

  // Sends 8 bits; checks done stays low until the final bit, then the result.
  task automatic send_frame(input logic [7:0] f, input logic gap, input string req);
    for (int i = 0; i < 8; i++) begin
      if (gap && i == 4) begin
        step(1'b0, 1'b0, 1'b1);
        chk("R4 gap", frame_done_o, parity_err_o, 1'b0, 1'b0);
      end
      step(1'b0, 1'b1, f[i]);
      if (i < 7) chk("R3 early", frame_done_o, parity_err_o, 1'b0, 1'b0);
    end
    chk(req, frame_done_o, parity_err_o, 1'b1, ^f);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog actual hung expected finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; sync_i = 1'b0; bit_valid_i = 1'b0; bit_i = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    chk("R1 reset", frame_done_o, parity_err_o, 1'b0, 1'b0);
    @(negedge clk); rst = 1'b0;

    // R6: bits before first sync are ignored.
    for (int i = 0; i < 10; i++) begin
      step(1'b0, 1'b1, 1'(i % 2));
      chk("R6 pre-sync", frame_done_o, parity_err_o, 1'b0, 1'b0);
    end

    // Vector table: R3 R4 R5 across patterns.
    foreach (VEC[k]) begin
      step(1'b1, 1'b0, 1'b0);
      send_frame(VEC[k][7:0], VEC[k][8], "R5 table");
      idle_check("R8 pulse end");
    end

    // R7: bits after a finished frame are ignored.
    step(1'b1, 1'b0, 1'b0);
    send_frame(8'h03, 1'b0, "R5 even");
    for (int i = 0; i < 12; i++) begin
      step(1'b0, 1'b1, 1'b1);
      chk("R7 post-frame", frame_done_o, parity_err_o, 1'b0, 1'b0);
    end

    // R2: resync in mid-frame after an odd prefix.
    step(1'b1, 1'b0, 1'b0);
    for (int i = 0; i < 5; i++) step(1'b0, 1'b1, 1'(i == 0));
    step(1'b1, 1'b0, 1'b0);
    chk("R2 resync", frame_done_o, parity_err_o, 1'b0, 1'b0);
    send_frame(8'h0F, 1'b0, "R2 restart");

    // R9: sync with a valid 1 bit; bit is dropped.
    step(1'b1, 1'b1, 1'b1);
    send_frame(8'h00, 1'b0, "R9 sync wins");

    // R8: sync right after done, back-to-back frame with odd parity.
    step(1'b1, 1'b0, 1'b0);
    chk("R8 single pulse", frame_done_o, parity_err_o, 1'b0, 1'b0);
    send_frame(8'h10, 1'b1, "R5 odd");

    // R1: reset mid-frame disarms the checker.
    step(1'b1, 1'b0, 1'b0);
    for (int i = 0; i < 4; i++) step(1'b0, 1'b1, 1'b1);
    @(negedge clk); rst = 1'b1; bit_valid_i = 1'b0;
    @(posedge clk); #1;
    @(negedge clk); rst = 1'b0;
    for (int i = 0; i < 8; i++) begin
      step(1'b0, 1'b1, 1'b0);
      chk("R1 disarmed", frame_done_o, parity_err_o, 1'b0, 1'b0);
    end

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule